// File: doc/BRIEF.md
# Two-Stage Multiple-Bus Arbiter

This block decides, every clock cycle, which processors may reach the shared memory units when the buses between them are fewer than the memory units. Each processor raises a request and names the memory unit it wants. Arbitration happens in two stages. First, every memory unit chooses one of the processors that target it. Second, an allocator hands the available buses to the memory units that found a winner in the first stage.

A processor is granted only when it wins both stages. The registered outputs give a grant bit for each processor and the bus index it was given. For each bus they also give an active flag, the processor it connects and the memory unit it connects. A processor that loses at either stage keeps its request raised and tries again. Both stages rotate priority, so no processor and no memory unit is starved. The data path and the bus timing sit outside this block.

Top module: `mbarb_top`

## Requirements
- R1: While `rstN` is low, every output is 0. All priority pointers return to processor 0 and memory unit 0, and the first grant after reset follows from those start values.
- R2: In any cycle, at most one processor is granted for each memory unit. A granted processor was requesting that memory unit in the cycle before. Processor i's target is `reqTarget[2i+1:2i]`, a binary memory-unit index.
- R3: Each memory unit picks among its requesters in round-robin order. The search starts at its pointer. After that unit's winner receives a bus, the pointer moves to one past the winner, wrapping from 7 to 0.
- R4: At most `NUM_BUS` processors are granted per cycle. Only memory units with a first-stage winner receive a bus.
- R5: Buses go to memory units in round-robin order, starting at the allocator pointer. Bus 0 takes the first memory unit found, bus 1 the next, and so on. After any allocation, the pointer moves to one past the last memory unit served.
- R6: A processor's grant bit is 1 exactly when some active bus names it. For active bus k, `busProc[3k+2:3k]` holds the processor index, `busMem[2k+1:2k]` holds the memory-unit index, and `grantBus` of that processor equals k. Fields of inactive buses and of ungranted processors read 0.
- R7: The outputs reflect the requests sampled at the previous rising clock edge.
- R8: No two active buses carry the same memory unit, and no two carry the same processor.
- R9: When a memory unit has a first-stage winner but gets no bus, its pointer does not move. The same processor wins that unit on its next attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 8 | Request flag of each processor |
| reqTarget | input | 16 | Target memory-unit index of each processor, 2 bits each |
| grant | output | 8 | Final grant of each processor |
| grantBus | output | 8 | Bus index given to each processor, 1 bit each |
| busActive | output | 2 | Bus carries a connection this cycle |
| busProc | output | 6 | Processor index connected to each bus, 3 bits each |
| busMem | output | 4 | Memory-unit index connected to each bus, 2 bits each |

## Verification
Two functions can fall in the same cycle and interact: a memory unit's round-robin choice among contending processors, and the allocator turning that unit away because the buses are already taken. The bench provokes this with three memory units that all have winners while only two buses exist. It also sets up contention on one unit across consecutive cycles, so both pointers act at the same time. Each case is judged on the exact processor, memory unit and bus named in the following cycle. A correct design re-offers the turned-away winner unchanged, and that outcome separates a pointer that moves only on a full grant from one that moves on a first-stage win.

// File: rtl/mbarb_pkg.sv
package mbarb_pkg;
  parameter int NUM_PROC = 8;
  parameter int NUM_MEM  = 4;
  parameter int NUM_BUS  = 2;
  localparam int PROC_W = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1;
  localparam int MEM_W  = (NUM_MEM > 1) ? $clog2(NUM_MEM) : 1;
  localparam int BUS_W  = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1;

  // strobes from control to datapath for one cycle
  typedef struct packed {
    logic [NUM_BUS-1:0]             busFill;
    logic [NUM_BUS-1:0][MEM_W-1:0]  busMemSel;
    logic [NUM_MEM-1:0][PROC_W-1:0] memWinner;
  } arbStrobe_t;
endpackage

// File: rtl/mbarb_rr_pick.sv
module mbarb_rr_pick #(
  parameter int WIDTH = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] req,
  input  logic             advance,
  output logic             found,
  output logic [IDX_W-1:0] winIdx
);
  logic [IDX_W-1:0] ptr;

  always_comb begin
    found  = 1'b0;
    winIdx = '0;
    for (int off = 0; off < WIDTH; off++) begin
      int idx;
      idx = (int'(ptr) + off) % WIDTH;
      if (!found && req[idx]) begin
        found  = 1'b1;
        winIdx = IDX_W'(idx);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ptr <= '0;
    else if (advance && found)
      ptr <= (int'(winIdx) == WIDTH - 1) ? '0 : winIdx + 1'b1;
  end
endmodule

// File: rtl/mbarb_ctrl.sv
module mbarb_ctrl
  import mbarb_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_PROC-1:0]             reqValid,
  input  logic [NUM_PROC-1:0][MEM_W-1:0]  reqTarget,
  output arbStrobe_t                      strobe
);
  logic [NUM_MEM-1:0]             memHas;
  logic [NUM_MEM-1:0]             memGot;
  logic [NUM_MEM-1:0][PROC_W-1:0] memWinner;
  logic [NUM_BUS-1:0]             busFill;
  logic [NUM_BUS-1:0][MEM_W-1:0]  busMemSel;

  // stage one: one round-robin picker per memory unit
  for (genvar j = 0; j < NUM_MEM; j++) begin : gMem
    logic [NUM_PROC-1:0] memReq;
    always_comb
      for (int i = 0; i < NUM_PROC; i++)
        memReq[i] = reqValid[i] && (int'(reqTarget[i]) == j);
    mbarb_rr_pick #(.WIDTH(NUM_PROC), .IDX_W(PROC_W)) u_pick (
      .clk(clk), .rstN(rstN), .req(memReq), .advance(memGot[j]),
      .found(memHas[j]), .winIdx(memWinner[j]));
  end

  // stage two: hand out buses
  if (NUM_BUS < NUM_MEM) begin : gAlloc
    logic [MEM_W-1:0] busPtr;
    logic [MEM_W-1:0] lastMem;
    always_comb begin
      int cnt;
      cnt       = 0;
      busFill   = '0;
      busMemSel = '0;
      memGot    = '0;
      lastMem   = '0;
      for (int off = 0; off < NUM_MEM; off++) begin
        int idx;
        idx = (int'(busPtr) + off) % NUM_MEM;
        if (memHas[idx] && cnt < NUM_BUS) begin
          busFill[cnt]   = 1'b1;
          busMemSel[cnt] = MEM_W'(idx);
          memGot[idx]    = 1'b1;
          lastMem        = MEM_W'(idx);
          cnt++;
        end
      end
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) busPtr <= '0;
      else if (|busFill)
        busPtr <= (int'(lastMem) == NUM_MEM - 1) ? '0 : lastMem + 1'b1;
    end
  end else begin : gDirect
    always_comb begin
      busFill   = '0;
      busMemSel = '0;
      memGot    = memHas;
      for (int k = 0; k < NUM_MEM; k++) begin
        busFill[k]   = memHas[k];
        busMemSel[k] = MEM_W'(k);
      end
    end
  end

  assign strobe.busFill   = busFill;
  assign strobe.busMemSel = busMemSel;
  assign strobe.memWinner = memWinner;
endmodule

// File: rtl/mbarb_dpath.sv
module mbarb_dpath
  import mbarb_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  arbStrobe_t                      strobe,
  output logic [NUM_PROC-1:0]             grant,
  output logic [NUM_PROC-1:0][BUS_W-1:0]  grantBus,
  output logic [NUM_BUS-1:0]              busActive,
  output logic [NUM_BUS-1:0][PROC_W-1:0]  busProc,
  output logic [NUM_BUS-1:0][MEM_W-1:0]   busMem
);
  logic [NUM_PROC-1:0]            grantNext;
  logic [NUM_PROC-1:0][BUS_W-1:0] grantBusNext;
  logic [NUM_BUS-1:0][PROC_W-1:0] busProcNext;
  logic [NUM_BUS-1:0][MEM_W-1:0]  busMemNext;

  always_comb begin
    grantNext    = '0;
    grantBusNext = '0;
    busProcNext  = '0;
    busMemNext   = '0;
    for (int k = 0; k < NUM_BUS; k++) begin
      if (strobe.busFill[k]) begin
        busMemNext[k]  = strobe.busMemSel[k];
        busProcNext[k] = strobe.memWinner[strobe.busMemSel[k]];
        grantNext[busProcNext[k]]    = 1'b1;
        grantBusNext[busProcNext[k]] = BUS_W'(k);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grant     <= '0;
      grantBus  <= '0;
      busActive <= '0;
      busProc   <= '0;
      busMem    <= '0;
    end else begin
      grant     <= grantNext;
      grantBus  <= grantBusNext;
      busActive <= strobe.busFill;
      busProc   <= busProcNext;
      busMem    <= busMemNext;
    end
  end
endmodule

// File: rtl/mbarb_top.sv
module mbarb_top
  import mbarb_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_PROC-1:0]       reqValid,
  input  logic [NUM_PROC*MEM_W-1:0] reqTarget,
  output logic [NUM_PROC-1:0]       grant,
  output logic [NUM_PROC*BUS_W-1:0] grantBus,
  output logic [NUM_BUS-1:0]        busActive,
  output logic [NUM_BUS*PROC_W-1:0] busProc,
  output logic [NUM_BUS*MEM_W-1:0]  busMem
);
  arbStrobe_t strobe;
  logic [NUM_PROC-1:0][BUS_W-1:0] grantBusW;
  logic [NUM_BUS-1:0][PROC_W-1:0] busProcW;
  logic [NUM_BUS-1:0][MEM_W-1:0]  busMemW;

  mbarb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqTarget(reqTarget),
    .strobe(strobe));

  mbarb_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .grant(grant),
    .grantBus(grantBusW), .busActive(busActive), .busProc(busProcW),
    .busMem(busMemW));

  assign grantBus = grantBusW;
  assign busProc  = busProcW;
  assign busMem   = busMemW;
endmodule

// File: rtl/mbarb_checker.sv
module mbarb_checker
  import mbarb_pkg::*;
(
  input logic                      clk,
  input logic                      rstN,
  input logic [NUM_PROC-1:0]       reqValid,
  input logic [NUM_PROC*MEM_W-1:0] reqTarget,
  input logic [NUM_PROC-1:0]       grant,
  input logic [NUM_BUS-1:0]        busActive,
  input logic [NUM_BUS*PROC_W-1:0] busProc,
  input logic [NUM_BUS*MEM_W-1:0]  busMem
);
  logic [NUM_PROC-1:0]       prevValid;
  logic [NUM_PROC*MEM_W-1:0] prevTarget;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevValid  <= '0;
      prevTarget <= '0;
    end else begin
      prevValid  <= reqValid;
      prevTarget <= reqTarget;
    end
  end

  assert_bus_budget_R4: assert property (@(posedge clk) disable iff (!rstN)
    $countones(grant) <= NUM_BUS);

  assert_grant_bus_match_R6: assert property (@(posedge clk) disable iff (!rstN)
    $countones(grant) == $countones(busActive));

  for (genvar i = 0; i < NUM_PROC; i++) begin : gProc
    assert_grant_requested_R7: assert property (@(posedge clk) disable iff (!rstN)
      grant[i] |-> prevValid[i]);
  end

  for (genvar k = 0; k < NUM_BUS; k++) begin : gBus
    logic [PROC_W-1:0] pIdx;
    assign pIdx = busProc[k*PROC_W +: PROC_W];
    assert_bus_target_R2: assert property (@(posedge clk) disable iff (!rstN)
      busActive[k] |-> (prevValid[pIdx] &&
        prevTarget[pIdx*MEM_W +: MEM_W] == busMem[k*MEM_W +: MEM_W] && grant[pIdx]));
    for (genvar l = k + 1; l < NUM_BUS; l++) begin : gPair
      assert_bus_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
        (busActive[k] && busActive[l]) |->
          (busMem[k*MEM_W +: MEM_W] != busMem[l*MEM_W +: MEM_W] &&
           busProc[k*PROC_W +: PROC_W] != busProc[l*PROC_W +: PROC_W]));
    end
  end
endmodule

bind mbarb_top mbarb_checker u_chk (.*);

// File: tb/mbarb_top_bench.sv
module mbarb_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  reqValid = '0;
  logic [15:0] reqTarget = '0;
  logic [7:0]  grant;
  logic [7:0]  grantBus;
  logic [1:0]  busActive;
  logic [5:0]  busProc;
  logic [3:0]  busMem;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  mbarb_top u_mbarb_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqTarget(reqTarget),
    .grant(grant), .grantBus(grantBus), .busActive(busActive),
    .busProc(busProc), .busMem(busMem));

  typedef struct packed {
    logic [7:0]  valid;
    logic [15:0] tgt;
    logic [7:0]  g;
    logic [1:0]  act;
    logic [5:0]  proc;
    logic [3:0]  mem;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t TABLE [NVEC] = '{
    '{8'h00, 16'h0000, 8'h00, 2'b00, 6'o00, 4'h0}, // idle, R7
    '{8'h01, 16'h0000, 8'h01, 2'b01, 6'o00, 4'h0}, // single request, R6
    '{8'h0F, 16'h0090, 8'h0C, 2'b11, 6'o32, 4'h9}, // M0 turned away, R5
    '{8'h0F, 16'h0090, 8'h06, 2'b11, 6'o21, 4'h4}, // M0 retries with P1, R9
    '{8'h0F, 16'h0090, 8'h09, 2'b11, 6'o03, 4'h2}, // M0 rotates to P0, R3
    '{8'hFF, 16'hFFFF, 8'h01, 2'b01, 6'o00, 4'h3}, // all on M3, R2
    '{8'hFF, 16'hFFFF, 8'h02, 2'b01, 6'o01, 4'h3}, // rotate on M3, R3
    '{8'hF0, 16'hE400, 8'h30, 2'b11, 6'o54, 4'h4}, // four units, two buses, R4
    '{8'hF0, 16'hE400, 8'hC0, 2'b11, 6'o76, 4'hE}, // allocator rotates, R5
    '{8'h00, 16'h0000, 8'h00, 2'b00, 6'o00, 4'h0}  // drop, R7
  };

  function automatic string tagOf(int v);
    case (v)
      0, 9: return "R7";
      1: return "R6";
      2, 8: return "R5";
      3: return "R9";
      4, 6: return "R3";
      5: return "R2";
      default: return "R4";
    endcase
  endfunction

  task automatic checkOut(string tag, logic [7:0] eg, logic [1:0] ea,
                          logic [5:0] ep, logic [3:0] em);
    logic [7:0] egb;
    egb = '0;
    for (int k = 0; k < 2; k++)
      if (ea[k]) egb[ep[k*3 +: 3]] = 1'(k);
    checks++;
    if (grant !== eg || busActive !== ea || busProc !== ep ||
        busMem !== em || grantBus !== egb) begin
      fails++;
      $display("FAIL %s grant=%h act=%b proc=%o mem=%h gbus=%h expected grant=%h act=%b proc=%o mem=%h gbus=%h",
               tag, grant, busActive, busProc, busMem, grantBus, eg, ea, ep, em, egb);
    end
  endtask

  task automatic stepCheck(string tag, logic [7:0] v, logic [15:0] t,
                           logic [7:0] eg, logic [1:0] ea,
                           logic [5:0] ep, logic [3:0] em);
    reqValid  = v;
    reqTarget = t;
    @(negedge clk);
    checkOut(tag, eg, ea, ep, em);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    reqValid = 8'hFF;
    @(negedge clk);
    checkOut("R1", 8'h00, 2'b00, 6'o00, 4'h0); // held in reset
    reqValid = '0;
    rstN = 1'b1;
    for (int v = 0; v < NVEC; v++)
      stepCheck(tagOf(v), TABLE[v].valid, TABLE[v].tgt, TABLE[v].g,
                TABLE[v].act, TABLE[v].proc, TABLE[v].mem);

    // R1: reset in mid run clears outputs and pointers
    reqValid = 8'h48;
    reqTarget = 16'h0000;
    @(negedge clk);
    rstN = 1'b0;
    #1;
    checkOut("R1", 8'h00, 2'b00, 6'o00, 4'h0);
    @(negedge clk);
    rstN = 1'b1;
    stepCheck("R1", 8'h48, 16'h0000, 8'h08, 2'b01, 6'o03, 4'h0); // P3 from ptr 0
    stepCheck("R3", 8'h48, 16'h0000, 8'h40, 2'b01, 6'o06, 4'h0); // rotates to P6
    // R9: M3 loses the bus, keeps P2 as its winner
    stepCheck("R5", 8'h17, 16'h0339, 8'h03, 2'b11, 6'o10, 4'h9);
    stepCheck("R9", 8'h17, 16'h0339, 8'h05, 2'b11, 6'o02, 4'h7);
    stepCheck("R7", 8'h00, 16'h0339, 8'h00, 2'b00, 6'o00, 4'h0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule